// File: doc/BRIEF.md
# Sprite Attribute Table with Anchor Grouping

This block keeps one attribute record per sprite and turns it into drawing-ready attributes on request. Software first writes a slot number, then streams bytes; each byte fills the next field of the record in that slot. When a record is complete, the block moves on to the following slot by itself, so a whole table can be loaded as one uninterrupted byte stream after a single slot select.

A sprite is either an anchor or a relative sprite. An anchor carries an absolute screen position. A relative sprite carries a signed offset and is placed against the nearest anchor at a lower index. Moving one anchor therefore moves its whole group. The drawing side presents a sprite index on the lookup port and, one clock later, receives the final position, visibility, mirror and rotate flags, palette offset and pattern number.

Top module: `spr_attr_table`

## Requirements
- R1: After reset every record reads as all zero, so every lookup returns position 0, invisible, no flags, palette 0 and pattern 0, with the relative flag clear.
- R2: A slot-select write sets the target slot and restarts the record at its first byte. A data write in the same cycle as a slot select is discarded.
- R3: Data bytes fill a record in the order X, Y, attribute, control. If control bit 6 is 0, the control byte ends the record and the slot advances, wrapping from the last slot to 0.
- R4: If control bit 6 is 1, a fifth mode byte is taken before the slot advances. The byte position never goes beyond the fifth byte.
- R5: Attribute byte: palette offset in bits 7:4, X mirror in bit 3, Y mirror in bit 2, rotate in bit 1, X bit 8 in bit 0. Control byte: visible in bit 7, pattern in bits 5:0. Palette, mirrors, rotate and pattern always come from the sprite's own record.
- R6: A sprite is relative only when control bit 6 is 1 and mode bits 7:6 are 01. Otherwise it is an anchor, placed at X = {attribute bit 0, X byte} and Y = Y byte, with visibility taken from its own visible bit.
- R7: A relative sprite is placed at the position of the nearest anchor at a lower index, plus its X and Y bytes read as signed 8-bit offsets. X is taken modulo 512 and Y modulo 256.
- R8: A relative sprite is visible only when it and its anchor are both visible. A relative sprite with no anchor below it is invisible and uses origin 0.
- R9: The result appears one clock after the index is presented. It reflects the table as it stood before any write made at that same edge.
- R10: Rewriting an anchor's position moves every relative sprite in its group on the next lookup.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| sel_we | input | 1 | Slot select strobe |
| sel_idx | input | IDX_W | Slot to fill next |
| data_we | input | 1 | Data byte strobe |
| data_byte | input | 8 | Record byte |
| qry_idx | input | IDX_W | Sprite index to resolve |
| res_x | output | 9 | Resolved X position |
| res_y | output | 8 | Resolved Y position |
| res_vis | output | 1 | Resolved visibility |
| res_rel | output | 1 | Sprite is relative |
| res_mirx | output | 1 | X mirror |
| res_miry | output | 1 | Y mirror |
| res_rot | output | 1 | Rotate |
| res_pal | output | 4 | Palette offset |
| res_pat | output | 6 | Pattern number |

## Verification
The bench builds the block with eight slots (NUM_SPR = 8). This puts the wrap from the last slot back to slot 0 within a few records. A full table scan takes eight cycles, so orphan relative sprites, chains that cross an invisible anchor, and X overflow past 511 can all be set up and revisited many times. A behavioural model then follows a long stream of mixed selects, bytes and lookups cycle by cycle.

// File: rtl/sat_pkg.sv
package sat_pkg;
  localparam int BYTE_W = 8;
  localparam int XW     = 9;
  localparam int YW     = 8;
  localparam int PAT_W  = 6;
  localparam int PAL_W  = 4;

  localparam logic [2:0] FLD_X    = 3'd0;
  localparam logic [2:0] FLD_Y    = 3'd1;
  localparam logic [2:0] FLD_ATTR = 3'd2;
  localparam logic [2:0] FLD_CTL  = 3'd3;
  localparam logic [2:0] FLD_MODE = 3'd4;

  localparam int CTL_VIS_BIT = 7;
  localparam int CTL_EXT_BIT = 6;
  localparam logic [1:0] MODE_REL = 2'b01;

  typedef struct packed {
    logic [BYTE_W-1:0] x;
    logic [BYTE_W-1:0] y;
    logic [BYTE_W-1:0] attr;
    logic              vis;
    logic              ext;
    logic [PAT_W-1:0]  pat;
    logic [1:0]        mode;
  } rec_t;

  typedef struct packed {
    logic [XW-1:0]    x;
    logic [YW-1:0]    y;
    logic             vis;
    logic             rel;
    logic             mirx;
    logic             miry;
    logic             rot;
    logic [PAL_W-1:0] pal;
    logic [PAT_W-1:0] pat;
  } res_t;
endpackage

// File: rtl/sat_loader.sv
module sat_loader
  import sat_pkg::*;
#(
  parameter int NUM_SPR = 128,
  parameter int IDX_W   = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_we,
  input  logic [IDX_W-1:0]  sel_idx,
  input  logic              data_we,
  input  logic [7:0]        data_byte,
  output logic              wr_en,
  output logic [IDX_W-1:0]  wr_slot,
  output logic [2:0]        wr_field
);
  localparam logic [IDX_W-1:0] LAST_SLOT = IDX_W'(NUM_SPR - 1);

  logic [IDX_W-1:0] slot_q, slot_d;
  logic [2:0]       ptr_q, ptr_d;
  logic             rec_end;
  logic             upd_en;

  always_comb begin
    wr_en   = data_we & ~sel_we;
    rec_end = ((ptr_q == FLD_CTL) && !data_byte[CTL_EXT_BIT]) || (ptr_q == FLD_MODE);
    upd_en  = sel_we | wr_en;
    slot_d  = slot_q;
    ptr_d   = ptr_q;
    if (sel_we) begin
      slot_d = sel_idx;
      ptr_d  = FLD_X;
    end else if (wr_en) begin
      if (rec_end) begin
        ptr_d  = FLD_X;
        slot_d = (slot_q == LAST_SLOT) ? '0 : slot_q + 1'b1;
      end else begin
        ptr_d = ptr_q + 3'd1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_q <= '0;
      ptr_q  <= FLD_X;
    end else if (upd_en) begin
      slot_q <= slot_d;
      ptr_q  <= ptr_d;
    end
  end

  assign wr_slot  = slot_q;
  assign wr_field = ptr_q;

  assert_ptr_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_q <= FLD_MODE);

  assert_select_R2: assert property (@(posedge clk) disable iff (!rst_n)
    sel_we |=> (slot_q == $past(sel_idx)) && (ptr_q == FLD_X));

  assert_short_advance_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (data_we && !sel_we && ptr_q == FLD_CTL && !data_byte[CTL_EXT_BIT])
      |=> (ptr_q == FLD_X) && (slot_q != $past(slot_q)));

  assert_ext_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (data_we && !sel_we && ptr_q == FLD_CTL && data_byte[CTL_EXT_BIT])
      |=> (ptr_q == FLD_MODE) && $stable(slot_q));
endmodule

// File: rtl/sat_store.sv
module sat_store
  import sat_pkg::*;
#(
  parameter int NUM_SPR = 128,
  parameter int IDX_W   = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_slot,
  input  logic [2:0]        wr_field,
  input  logic [7:0]        wr_byte,
  input  logic [IDX_W-1:0]  own_idx,
  input  logic [IDX_W-1:0]  anc_idx,
  output rec_t              own_rec,
  output logic [XW-1:0]     anc_x,
  output logic [YW-1:0]     anc_y,
  output logic              anc_vis,
  output logic [NUM_SPR-1:0] is_anchor
);
  rec_t rec_q [NUM_SPR];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_SPR; i++) rec_q[i] <= '0;
    end else if (wr_en) begin
      case (wr_field)
        FLD_X:    rec_q[wr_slot].x    <= wr_byte;
        FLD_Y:    rec_q[wr_slot].y    <= wr_byte;
        FLD_ATTR: rec_q[wr_slot].attr <= wr_byte;
        FLD_CTL: begin
          rec_q[wr_slot].vis <= wr_byte[CTL_VIS_BIT];
          rec_q[wr_slot].ext <= wr_byte[CTL_EXT_BIT];
          rec_q[wr_slot].pat <= wr_byte[PAT_W-1:0];
        end
        default:  rec_q[wr_slot].mode <= wr_byte[7:6];
      endcase
    end
  end

  for (genvar g = 0; g < NUM_SPR; g++) begin : g_kind
    assign is_anchor[g] = !(rec_q[g].ext && (rec_q[g].mode == MODE_REL));
  end

  always_comb begin
    own_rec = rec_q[own_idx];
    anc_x   = {rec_q[anc_idx].attr[0], rec_q[anc_idx].x};
    anc_y   = rec_q[anc_idx].y;
    anc_vis = rec_q[anc_idx].vis;
  end
endmodule

// File: rtl/sat_anchor_find.sv
module sat_anchor_find #(
  parameter int NUM_SPR = 128,
  parameter int IDX_W   = 7
) (
  input  logic [NUM_SPR-1:0] is_anchor,
  input  logic [IDX_W-1:0]   qry_idx,
  output logic               found,
  output logic [IDX_W-1:0]   anc_idx
);
  always_comb begin
    found   = 1'b0;
    anc_idx = '0;
    for (int j = 0; j < NUM_SPR; j++) begin
      if ((IDX_W'(j) < qry_idx) && is_anchor[j]) begin
        found   = 1'b1;
        anc_idx = IDX_W'(j);
      end
    end
  end
endmodule

// File: rtl/sat_resolve.sv
module sat_resolve
  import sat_pkg::*;
(
  input  rec_t           own_rec,
  input  logic           found,
  input  logic [XW-1:0]  anc_x,
  input  logic [YW-1:0]  anc_y,
  input  logic           anc_vis,
  output res_t           res
);
  logic          rel;
  logic [XW-1:0] base_x;
  logic [YW-1:0] base_y;
  logic [XW-1:0] off_x;

  always_comb begin
    rel    = own_rec.ext && (own_rec.mode == MODE_REL);
    base_x = found ? anc_x : '0;
    base_y = found ? anc_y : '0;
    off_x  = {own_rec.x[7], own_rec.x};

    res.rel  = rel;
    res.pal  = own_rec.attr[7:4];
    res.mirx = own_rec.attr[3];
    res.miry = own_rec.attr[2];
    res.rot  = own_rec.attr[1];
    res.pat  = own_rec.pat;
    if (rel) begin
      res.x   = base_x + off_x;
      res.y   = base_y + own_rec.y;
      res.vis = own_rec.vis && found && anc_vis;
    end else begin
      res.x   = {own_rec.attr[0], own_rec.x};
      res.y   = own_rec.y;
      res.vis = own_rec.vis;
    end
  end
endmodule

// File: rtl/spr_attr_table.sv
module spr_attr_table
  import sat_pkg::*;
#(
  parameter int NUM_SPR = 128,
  localparam int IDX_W  = $clog2(NUM_SPR)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel_we,
  input  logic [IDX_W-1:0] sel_idx,
  input  logic             data_we,
  input  logic [7:0]       data_byte,
  input  logic [IDX_W-1:0] qry_idx,
  output logic [8:0]       res_x,
  output logic [7:0]       res_y,
  output logic             res_vis,
  output logic             res_rel,
  output logic             res_mirx,
  output logic             res_miry,
  output logic             res_rot,
  output logic [3:0]       res_pal,
  output logic [5:0]       res_pat
);
  logic rst_s1_q, rst_s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q <= 1'b0;
      rst_s2_q <= 1'b0;
    end else begin
      rst_s1_q <= 1'b1;
      rst_s2_q <= rst_s1_q;
    end
  end

  logic               wr_en;
  logic [IDX_W-1:0]   wr_slot;
  logic [2:0]         wr_field;
  rec_t               own_rec;
  logic [XW-1:0]      anc_x;
  logic [YW-1:0]      anc_y;
  logic               anc_vis;
  logic [NUM_SPR-1:0] is_anchor;
  logic               found;
  logic [IDX_W-1:0]   anc_idx;
  res_t               res_d, res_q;

  sat_loader #(.NUM_SPR(NUM_SPR), .IDX_W(IDX_W)) u_loader (
    .clk(clk), .rst_n(rst_s2_q),
    .sel_we(sel_we), .sel_idx(sel_idx),
    .data_we(data_we), .data_byte(data_byte),
    .wr_en(wr_en), .wr_slot(wr_slot), .wr_field(wr_field)
  );

  sat_store #(.NUM_SPR(NUM_SPR), .IDX_W(IDX_W)) u_store (
    .clk(clk), .rst_n(rst_s2_q),
    .wr_en(wr_en), .wr_slot(wr_slot), .wr_field(wr_field), .wr_byte(data_byte),
    .own_idx(qry_idx), .anc_idx(anc_idx),
    .own_rec(own_rec), .anc_x(anc_x), .anc_y(anc_y), .anc_vis(anc_vis),
    .is_anchor(is_anchor)
  );

  sat_anchor_find #(.NUM_SPR(NUM_SPR), .IDX_W(IDX_W)) u_find (
    .is_anchor(is_anchor), .qry_idx(qry_idx),
    .found(found), .anc_idx(anc_idx)
  );

  sat_resolve u_resolve (
    .own_rec(own_rec), .found(found),
    .anc_x(anc_x), .anc_y(anc_y), .anc_vis(anc_vis),
    .res(res_d)
  );

  always_ff @(posedge clk or negedge rst_s2_q) begin
    if (!rst_s2_q) res_q <= '0;
    else           res_q <= res_d;
  end

  assign res_x    = res_q.x;
  assign res_y    = res_q.y;
  assign res_vis  = res_q.vis;
  assign res_rel  = res_q.rel;
  assign res_mirx = res_q.mirx;
  assign res_miry = res_q.miry;
  assign res_rot  = res_q.rot;
  assign res_pal  = res_q.pal;
  assign res_pat  = res_q.pat;

  assert_anchor_below_R7: assert property (@(posedge clk) disable iff (!rst_s2_q)
    found |-> (anc_idx < qry_idx) && is_anchor[anc_idx]);

  assert_orphan_hidden_R8: assert property (@(posedge clk) disable iff (!rst_s2_q)
    (!is_anchor[qry_idx] && !found) |=> !res_vis);

  assert_hidden_anchor_R8: assert property (@(posedge clk) disable iff (!rst_s2_q)
    (!is_anchor[qry_idx] && found && !anc_vis) |=> !res_vis && res_rel);

  assert_anchor_pos_R6: assert property (@(posedge clk) disable iff (!rst_s2_q)
    is_anchor[qry_idx] |=> !res_rel && (res_y == $past(own_rec.y)));
endmodule

// File: tb/spr_attr_table_bench.sv
module spr_attr_table_bench;
  localparam int N  = 8;
  localparam int IW = $clog2(N);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          sel_we = 1'b0;
  logic [IW-1:0] sel_idx = '0;
  logic          data_we = 1'b0;
  logic [7:0]    data_byte = '0;
  logic [IW-1:0] qry_idx = '0;
  logic [8:0]    res_x;
  logic [7:0]    res_y;
  logic          res_vis, res_rel, res_mirx, res_miry, res_rot;
  logic [3:0]    res_pal;
  logic [5:0]    res_pat;

  int checks = 0;
  int errors = 0;
  string tag = "R1";
  bit cmp_on = 1'b0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  spr_attr_table #(.NUM_SPR(N)) u_spr_attr_table (
    .clk(clk), .rst_n(rst_n), .sel_we(sel_we), .sel_idx(sel_idx),
    .data_we(data_we), .data_byte(data_byte), .qry_idx(qry_idx),
    .res_x(res_x), .res_y(res_y), .res_vis(res_vis), .res_rel(res_rel),
    .res_mirx(res_mirx), .res_miry(res_miry), .res_rot(res_rot),
    .res_pal(res_pal), .res_pat(res_pat)
  );

  // behavioural model: five bytes per slot
  int m_b [N][5];
  int m_slot, m_ptr;
  logic [31:0] exp_q;

  function automatic bit m_rel(int i);
    return ((m_b[i][3] >> 6) & 1) == 1 && ((m_b[i][4] >> 6) & 3) == 1;
  endfunction

  function automatic logic [31:0] m_resolve(int i);
    int x, y, a, vis, ax, ay, avis, off;
    bit found;
    a = m_b[i][2];
    if (!m_rel(i)) begin
      x = ((a & 1) << 8) + m_b[i][0];
      y = m_b[i][1];
      vis = (m_b[i][3] >> 7) & 1;
    end else begin
      found = 0; ax = 0; ay = 0; avis = 0;
      for (int j = i - 1; j >= 0 && !found; j--) begin
        if (!m_rel(j)) begin
          found = 1;
          ax = ((m_b[j][2] & 1) << 8) + m_b[j][0];
          ay = m_b[j][1];
          avis = (m_b[j][3] >> 7) & 1;
        end
      end
      off = m_b[i][0] >= 128 ? m_b[i][0] - 256 : m_b[i][0];
      x = (ax + off + 512) % 512;
      off = m_b[i][1] >= 128 ? m_b[i][1] - 256 : m_b[i][1];
      y = (ay + off + 256) % 256;
      vis = (found && avis && ((m_b[i][3] >> 7) & 1)) ? 1 : 0;
    end
    return {9'(x), 8'(y), 1'(vis), 1'(m_rel(i)), 1'((a >> 3) & 1), 1'((a >> 2) & 1),
            1'((a >> 1) & 1), 4'((a >> 4) & 15), 6'(m_b[i][3] & 63)};
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) for (int k = 0; k < 5; k++) m_b[i][k] = 0;
      m_slot = 0; m_ptr = 0; exp_q = '0;
    end else begin
      exp_q = m_resolve(int'(qry_idx));
      if (sel_we) begin
        m_slot = int'(sel_idx); m_ptr = 0;
      end else if (data_we) begin
        m_b[m_slot][m_ptr] = int'(data_byte);
        if ((m_ptr == 3 && !data_byte[6]) || m_ptr == 4) begin
          m_ptr = 0; m_slot = (m_slot + 1) % N;
        end else m_ptr++;
      end
    end
  end

  function automatic logic [31:0] dut_out();
    return {res_x, res_y, res_vis, res_rel, res_mirx, res_miry, res_rot, res_pal, res_pat};
  endfunction

  task automatic check(string t, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%08h expected=%08h at %0t", t, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (cmp_on && !done) check(tag, dut_out(), exp_q);

  task automatic cyc(bit sw, int si, bit dw, int db, int q);
    @(negedge clk);
    sel_we = sw; sel_idx = IW'(si); data_we = dw; data_byte = 8'(db); qry_idx = IW'(q);
  endtask

  task automatic sel(int s);  cyc(1, s, 0, 0, int'(qry_idx)); endtask
  task automatic wr(int b);   cyc(0, 0, 1, b, int'(qry_idx)); endtask
  task automatic idle();      cyc(0, 0, 0, 0, int'(qry_idx)); endtask
  task automatic scan();
    for (int i = 0; i < N; i++) cyc(0, 0, 0, 0, i);
    idle();
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1: reset contents
    check("R1", dut_out(), 32'h0);
    cmp_on = 1'b1;
    tag = "R1"; scan();

    // R3/R4/R5/R6: slot 0 extended anchor, slot 1 relative
    tag = "R4"; sel(0);
    wr(100); wr(50); wr(8'hA5); wr(8'hC5); wr(8'h00);
    wr(8'hF0); wr(8'h10); wr(8'h3E); wr(8'hC9); wr(8'h40);
    tag = "R5"; cyc(0, 0, 0, 0, 0); idle();
    check("R5", dut_out(), {9'd356, 8'd50, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 4'hA, 6'd5});
    tag = "R7"; cyc(0, 0, 0, 0, 1); idle();
    check("R7", dut_out(), {9'd340, 8'd66, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 4'h3, 6'd9});

    // R8: relative behind hidden anchor, and mode 0x7F counts as relative
    tag = "R8";
    wr(5); wr(8'hFB); wr(8'h00); wr(8'hC1); wr(8'h7F);
    wr(20); wr(30); wr(8'h11); wr(8'h02);
    wr(3); wr(4); wr(8'h00); wr(8'hC3); wr(8'h40);
    tag = "R6"; wr(1); wr(2); wr(8'h01); wr(8'h44); wr(8'h80);
    tag = "R3"; wr(7); wr(8); wr(8'h20); wr(8'h85);
    wr(9); wr(10); wr(8'h00); wr(8'h86);
    scan();
    // R3: stream wraps to slot 0; slot 0 becomes an orphan relative
    wr(8'h10); wr(8'h20); wr(8'h00); wr(8'hC0); wr(8'h40);
    tag = "R8"; cyc(0, 0, 0, 0, 0); idle();
    check("R8", dut_out(), {9'd16, 8'd32, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 4'h0, 6'd0});
    scan();

    // R2: select with simultaneous data write, data discarded
    tag = "R2";
    cyc(1, 3, 1, 8'hEE, 3);
    wr(8'hFE); wr(8'h05); wr(8'h01); wr(8'h81);
    idle(); scan();

    // R10: move anchor 3 and revisit its group (X wraps past 511 too)
    tag = "R10";
    sel(3); wr(8'hFF); wr(8'h7F); wr(8'h01);
    cyc(0, 0, 0, 0, 4); idle();
    check("R10", dut_out(), {9'd2, 8'd131, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 4'h0, 6'd3});
    wr(8'h80);
    scan();

    // R9: mixed traffic with lookups every cycle
    tag = "R9";
    for (int k = 0; k < 3000; k++) begin
      int r = int'($urandom_range(0, 99));
      if (r < 5) cyc(1, int'($urandom_range(0, N - 1)), r < 2, int'($urandom_range(0, 255)),
                     int'($urandom_range(0, N - 1)));
      else if (r < 70) cyc(0, 0, 1, int'($urandom_range(0, 255)), int'($urandom_range(0, N - 1)));
      else cyc(0, 0, 0, 0, int'($urandom_range(0, N - 1)));
    end
    idle(); scan();
    finish_run();
  end
endmodule